// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control side of a 10-bit successive-approximation analog-to-digital converter in a microcontroller peripheral. Software programs it through a small byte-wide register bus. One register holds the run bit and another holds the analog channel number. Setting the run bit starts a conversion. While the run bit stays set, conversions follow one another with no gap, and each one ends with a fresh result and a one-clock interrupt pulse.

Each conversion runs a fixed schedule. A settle wait comes first, then a sampling window with the track switch closed. After that come one trial per result bit, from the most significant bit down. On every trial the sequencer drives a candidate code to the external DAC and reads back a single comparator bit. When the last trial is done, the code is copied into a 16-bit, left-justified result word. Software can read that word either through two byte addresses or as a whole from a parallel output. Writing the channel number while the block is running throws away the conversion in progress and starts again. Clearing the run bit stops the block quietly.

Top module: `sar_seq_top`

## Requirements
- R1: While reset is asserted and after it is released, the result word reads 0x0000, the interrupt output is low and the sampling output is low.
- R2: A write of 1 to bit 0 of address 0, made while the run bit is clear, starts a conversion. Counting from the clock edge that accepts the write, its result and interrupt appear 1 + WAIT_CYC + SMP_CYC + RES_W edges later, which is 21 with the default parameters.
- R3: Each conversion runs WAIT_CYC clocks of wait with the sampling output low, then SMP_CYC clocks with the sampling output high, then RES_W trial clocks. The first trial drives a code with only the MSB set.
- R4: On each trial the candidate bit is kept when the comparator input is 1 and cleared when it is 0. As a result, a comparator that reports code <= level yields the level itself.
- R5: The interrupt output is high for exactly one clock, on the same edge where the result word takes its new value.
- R6: While the block stays enabled, a new sampling window starts straight after each transfer. Results therefore repeat every SMP_CYC + RES_W clocks, which is 18 with the default parameters.
- R7: The result word holds the 10-bit code in bits 15..6, and bits 5..0 are zero. A read of address 3 returns bits 15..8 and a read of address 2 returns bits 7..0.
- R8: The result word changes only at a transfer.
- R9: A write to address 1 (channel, bits 1..0) made while enabled drops the partial conversion and restarts from the wait phase, with the same latency as R2. The result word is not updated at that point. The same write made while disabled starts nothing.
- R10: A write of 0 to bit 0 of address 0 aborts any conversion. No interrupt follows, the result word keeps its value and the sampling output goes low.
- R11: A write of 1 to address 0 made while already enabled does not restart the schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 control, 1 channel, 2 result low byte, 3 result high byte |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| comp_i | input | 1 | Comparator decision for the current DAC code |
| chan_sel_o | output | 2 | Selected analog channel |
| sample_o | output | 1 | High during the sampling window |
| dac_code_o | output | 10 | Candidate code for the DAC |
| result_o | output | 16 | Left-justified result word |
| irq_o | output | 1 | One-clock conversion-complete pulse |

## Verification
Every result is due a fixed number of edges after the write that triggers it. The first result comes 21 edges after a start or channel rewrite, and each later one follows 18 edges after the one before. For each expected result, the driver stores both the expected word and its due edge. The monitor samples on falling edges and compares the actual edge of each interrupt against the stored due edge, so a result that arrives early, late, without being expected or not at all is caught. The phase checks are made on the falling edges 2, 3, 10 and 11 cycles after the start edge, which is where the wait/sample and sample/trial boundaries fall.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SAMPLE,
    ST_CONV
  } seq_state_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_CHAN   = 2'd1;
  localparam logic [1:0] ADDR_RES_LO = 2'd2;
  localparam logic [1:0] ADDR_RES_HI = 2'd3;
endpackage

// File: rtl/sar_regs.sv
module sar_regs
  import sar_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [7:0]      bus_wdata,
  output logic            en_o,
  output logic [CH_W-1:0] chan_o,
  output logic            restart_o
);
  logic            en_q;
  logic [CH_W-1:0] chan_q;
  logic            restart_q;
  logic            unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      chan_q    <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          ADDR_CTRL: begin
            if (bus_wdata[0] && !en_q) restart_q <= 1'b1;
            en_q <= bus_wdata[0];
          end
          ADDR_CHAN: begin
            chan_q <= bus_wdata[CH_W-1:0];
            if (en_q) restart_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign en_o      = en_q;
  assign chan_o    = chan_q;
  assign restart_o = restart_q;
endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
  import sar_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int WAIT_CYC = 2,
  parameter int SMP_CYC  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             comp_i,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic             xfer_o,
  output logic [RES_W-1:0] code_o
);
  localparam int CNT_MAX = (WAIT_CYC > SMP_CYC) ? WAIT_CYC : SMP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int IDX_W   = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] SMP_LAST  = CNT_W'(SMP_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_TOP   = IDX_W'(RES_W - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] sar_q;
  logic [RES_W-1:0] trial_mask;

  assign trial_mask = (state_q == ST_CONV) ? (RES_W'(1) << idx_q) : '0;
  assign dac_code_o = sar_q | trial_mask;
  assign code_o     = sar_q | (comp_i ? trial_mask : '0);
  assign sample_o   = (state_q == ST_SAMPLE);
  assign xfer_o     = en_i && !restart_i && (state_q == ST_CONV) && (idx_q == '0);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sar_q   <= '0;
    end else if (restart_i) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      sar_q   <= '0;
    end else begin
      case (state_q)
        ST_WAIT: begin
          if (cnt_q == WAIT_LAST) begin
            state_q <= ST_SAMPLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (cnt_q == SMP_LAST) begin
            state_q <= ST_CONV;
            cnt_q   <= '0;
            idx_q   <= IDX_TOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CONV: begin
          if (idx_q == '0) begin
            sar_q   <= '0;
            state_q <= ST_SAMPLE;
            cnt_q   <= '0;
          end else begin
            sar_q <= code_o;
            idx_q <= idx_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R10: a cleared run bit leaves the sequencer idle on the next clock
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (state_q == ST_IDLE));

  // R9: a restart request throws away the partial code and re-enters the wait phase
  a_r9_restart_clears: assert property (@(posedge clk) disable iff (rst)
    (en_i && restart_i) |=> (state_q == ST_WAIT && sar_q == '0));

  // R6: a transfer is followed at once by a new sampling window
  a_r6_resample: assert property (@(posedge clk) disable iff (rst)
    xfer_o |=> sample_o);
endmodule

// File: rtl/sar_result.sv
module sar_result
  import sar_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int WORD_W = 16,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_i,
  input  logic [RES_W-1:0]  code_i,
  input  logic              en_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [1:0]        bus_addr,
  output logic [7:0]        bus_rdata,
  output logic [WORD_W-1:0] result_o,
  output logic              irq_o
);
  localparam int PAD_W = WORD_W - RES_W;

  logic [WORD_W-1:0] res_q;
  logic              irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= xfer_i;
      if (xfer_i) res_q <= {code_i, {PAD_W{1'b0}}};
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL:   bus_rdata = {7'd0, en_i};
      ADDR_CHAN:   bus_rdata = 8'(chan_i);
      ADDR_RES_LO: bus_rdata = res_q[7:0];
      default:     bus_rdata = res_q[WORD_W-1:WORD_W-8];
    endcase
  end

  assign result_o = res_q;
  assign irq_o    = irq_q;

  // R5: the completion pulse lasts a single clock
  a_r5_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  // R8: the result word moves only together with the completion pulse
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_q) |-> irq_q);
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int WORD_W   = 16,
  parameter int CH_W     = 2,
  parameter int WAIT_CYC = 2,
  parameter int SMP_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              comp_i,
  output logic [CH_W-1:0]   chan_sel_o,
  output logic              sample_o,
  output logic [RES_W-1:0]  dac_code_o,
  output logic [WORD_W-1:0] result_o,
  output logic              irq_o
);
  logic             en;
  logic             restart;
  logic             xfer;
  logic [RES_W-1:0] code;

  sar_regs #(.CH_W(CH_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .en_o      (en),
    .chan_o    (chan_sel_o),
    .restart_o (restart)
  );

  sar_fsm #(.RES_W(RES_W), .WAIT_CYC(WAIT_CYC), .SMP_CYC(SMP_CYC)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en),
    .restart_i  (restart),
    .comp_i     (comp_i),
    .sample_o   (sample_o),
    .dac_code_o (dac_code_o),
    .xfer_o     (xfer),
    .code_o     (code)
  );

  sar_result #(.RES_W(RES_W), .WORD_W(WORD_W), .CH_W(CH_W)) u_result (
    .clk       (clk),
    .rst       (rst),
    .xfer_i    (xfer),
    .code_i    (code),
    .en_i      (en),
    .chan_i    (chan_sel_o),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .result_o  (result_o),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/sar_seq_top_bench.sv
`timescale 1ns/1ps
module sar_seq_top_bench;
  localparam int FIRST  = 21;
  localparam int PERIOD = 18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic        comp;
  logic [1:0]  chan_sel;
  logic        sample;
  logic [9:0]  dac_code;
  logic [15:0] result;
  logic        irq;

  typedef struct { logic [15:0] word; int due; } item_t;
  item_t exp_q[$];

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  logic [15:0] last_res = 16'h0;
  logic [9:0] level [4];

  always #2.5 clk = ~clk;

  // comparator model: keep a bit while the DAC code does not exceed the channel level
  assign comp = (dac_code <= level[chan_sel]);

  sar_seq_top u_sar_seq_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .comp_i(comp),
    .chan_sel_o(chan_sel), .sample_o(sample), .dac_code_o(dac_code),
    .result_o(result), .irq_o(irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 20000) begin
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
    finish_up();
  end

  // monitor: pops expected items on each completion pulse
  always @(negedge clk) if (!rst) begin
    if (irq) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5/R10 unexpected irq", 1, 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(result == it.word, "R4/R7 result word", result, it.word);
        check(cyc == it.due, "R2/R6 completion edge", cyc, it.due);
      end
    end else if (result != last_res) begin
      check(1'b0, "R8 result changed without irq", result, last_res);
    end
    last_res = result;
  end

  task automatic push(input logic [15:0] w, input int due);
    item_t it;
    it.word = w;
    it.due = due;
    exp_q.push_back(it);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, output int edge_no);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    edge_no = cyc + 1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int e, x, w, w2, w3, a, e2, dummy;
    logic [7:0] rb;
    level[0] = 10'h2A5; level[1] = 10'h000; level[2] = 10'h3FF; level[3] = 10'h155;

    wait_n(4);
    check(result == 16'h0, "R1 result in reset", result, 0);
    check(irq == 1'b0, "R1 irq in reset", irq, 0);
    rst = 1'b0;
    wait_n(2);
    check(sample == 1'b0, "R1 sample after reset", sample, 0);
    bus_read(2'd2, rb); check(rb == 8'h00, "R1 low byte", rb, 0);
    bus_read(2'd3, rb); check(rb == 8'h00, "R1 high byte", rb, 0);

    // R9: channel write while disabled starts nothing
    bus_write(2'd1, 8'd0, dummy);
    wait_n(30);
    check(sample == 1'b0, "R9 no start when disabled", sample, 0);

    // R2/R3/R6: start and three back-to-back results
    bus_write(2'd0, 8'd1, e);
    push(16'hA940, e + FIRST);
    push(16'hA940, e + FIRST + PERIOD);
    push(16'hA940, e + FIRST + 2 * PERIOD);
    wait_until(e + 2);  check(sample == 1'b0, "R3 wait phase", sample, 0);
    wait_until(e + 3);  check(sample == 1'b1, "R3 sample start", sample, 1);
    wait_until(e + 10); check(sample == 1'b1, "R3 sample end", sample, 1);
    wait_until(e + 11);
    check(sample == 1'b0, "R3 trial phase", sample, 0);
    check(dac_code == 10'h200, "R3 MSB trial first", dac_code, 10'h200);
    wait_until(e + FIRST + 2 * PERIOD);
    bus_read(2'd3, rb); check(rb == 8'hA9, "R7 high byte", rb, 8'hA9);
    bus_read(2'd2, rb); check(rb == 8'h40, "R7 low byte", rb, 8'h40);

    // R11: rewrite of 1 while running does not restart
    push(16'hA940, e + FIRST + 3 * PERIOD);
    bus_write(2'd0, 8'd1, x);
    wait_until(e + FIRST + 3 * PERIOD + 1);

    // R9: channel rewrite mid-conversion restarts, partial result discarded
    wait_n(4);
    bus_write(2'd1, 8'd1, w);
    push(16'h0000, w + FIRST);
    push(16'h0000, w + FIRST + PERIOD);
    wait_until(w + 15);
    check(result == 16'hA940, "R9 result kept across restart", result, 16'hA940);
    wait_until(w + FIRST + PERIOD + 3);

    bus_write(2'd1, 8'd2, w2);
    push(16'hFFC0, w2 + FIRST);
    wait_until(w2 + FIRST + 2);

    bus_write(2'd1, 8'd3, w3);
    push(16'h5540, w3 + FIRST);
    wait_until(w3 + FIRST + 8);

    // R10: abort mid-conversion
    bus_write(2'd0, 8'd0, a);
    wait_n(50);
    check(result == 16'h5540, "R10 result held after abort", result, 16'h5540);
    check(sample == 1'b0, "R10 sample low after abort", sample, 0);
    check(exp_q.size() == 0, "R10 no pending results", exp_q.size(), 0);

    // restart after abort on channel 0
    bus_write(2'd1, 8'd0, dummy);
    bus_write(2'd0, 8'd1, e2);
    push(16'hA940, e2 + FIRST);
    wait_until(e2 + FIRST + 2);
    bus_write(2'd0, 8'd0, dummy);
    wait_n(30);
    check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
    finish_up();
  end
endmodule